// File: doc/BRIEF.md
# PWM Modulator with Maximum-Duty Timeout

This block turns a digital duty command into the high-side request of a synchronous buck converter. A free-running phase counter divides the system clock into fixed switching periods (278 cycles of a 250 MHz clock gives about 900 kHz). The counter also serves as a digital ramp that starts at an offset code. The request is set at the start of every period. It is cleared on the trailing edge, when the ramp code reaches the duty command. The clearing side of the latch always wins over the setting side.

A run guard counts whole periods in which the request never dropped. When the count reaches its limit, the guard forces the request low from the middle of the next period. The low side of the bridge then conducts for half a period and recharges the bootstrap supply. A pulse that starts from low is held for a minimum on-time. A fault input clears the request and the run count at the next clock edge.

The duty code maps onto the ramp as follows. Code `RAMP_OFS` is the bottom of the ramp (0 % duty). Code `RAMP_OFS + PERIOD_CYC` is the top (100 % duty). Each ramp step lasts one clock cycle.

Top module: `pwm_maxduty_mod`

## Requirements
- R1: A switching period lasts exactly `PERIOD_CYC` clock cycles. Within a period the request is high in a single run that begins in the period's first cycle (phase 0). It never rises anywhere else.
- R2: Let n = `duty_cmd - RAMP_OFS`, limited to the range 0 to `PERIOD_CYC`. For a pulse that is not stretched, shortened or forced off, the request is high for exactly n cycles of the period.
- R3: A duty command at or below `RAMP_OFS` keeps the request low for the whole period. In that case the set at the period start and the ramp clear occur together, and the clear wins.
- R4: A duty command at or above `RAMP_OFS + PERIOD_CYC` keeps the request high for every cycle of the period.
- R5: After `MAX_RUNS` (20) consecutive periods with the request high in every cycle, the next period is high only for its first `PERIOD_CYC/2` cycles. The run count then starts again from zero.
- R6: Any period in which the request is low for at least one cycle clears the run count. A new run of `MAX_RUNS` full periods is needed before the next forced clear.
- R7: A pulse that rises from low stays high for at least `MIN_ON` cycles (23 cycles, about 90 ns), even when the command asks for fewer. An exception is a fault, which ends the pulse at once. A pulse that continues from a fully high period ends at n as in R2.
- R8: While `fault` is high, the request is low from the next clock edge onward. The fault also clears the run count.
- R9: The duty command is captured once, at the start of each period. Changing `duty_cmd` later in the period has no effect on that period's pulse.
- R10: While reset is asserted the request is low. It stays low until the first period start after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| duty_cmd | input | CMD_W | Duty command code, compared against the ramp code |
| fault | input | 1 | Fault flag: clears the request and the run count |
| pwm_req | output | 1 | High-side on request (low means the low side may conduct) |

## Verification
Both the latch and the phase counter are registered, and the next state is decoded from the next phase. The first high cycle of a pulse is therefore the cycle in which the phase reads 0. The duty applied to a period must be on `duty_cmd` before the clock edge that enters phase 0. A fault raised before an edge shows as a low request in the cycle after that edge. The forced clear after a full run takes effect in the cycle whose phase is `PERIOD_CYC/2`. The bench locks onto the first rising edge after reset. From then on it drives inputs and samples the request on falling clock edges, one sample per phase. It counts the high samples of each period and compares the count with a value computed from the command, from whether the previous period was full, and from its own count of full periods. It also checks that the high samples form a single run starting at phase 0.

// File: rtl/pwm_mod_pkg.sv
package pwm_mod_pkg;

  // Reason the latch is cleared in a given cycle, in priority order.
  typedef enum logic [1:0] {
    CLR_NONE    = 2'd0,
    CLR_RAMP    = 2'd1,
    CLR_TIMEOUT = 2'd2,
    CLR_FAULT   = 2'd3
  } clr_cause_e;

  // Decoded phase events shared by the sub-blocks.
  typedef struct packed {
    logic first;     // current phase is 0
    logic last;      // current phase is the final one of the period
    logic start_nx;  // next phase is 0 (period boundary at this edge)
    logic mid_nx;    // next phase is the period midpoint
  } phase_flags_t;

endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  // Assert immediately, release after STAGES clock edges.
  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/pwm_phase_gen.sv
module pwm_phase_gen
  import pwm_mod_pkg::*;
#(
  parameter  int PERIOD_CYC = 278,
  localparam int PH_W       = $clog2(PERIOD_CYC)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [PH_W-1:0] phase_q,
  output logic [PH_W-1:0] phase_nx,
  output phase_flags_t    flags
);

  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD_CYC - 1);
  localparam logic [PH_W-1:0] PH_MID  = PH_W'(PERIOD_CYC / 2);

  logic [PH_W-1:0] phase_d;

  // Next-state decode: wrap at the final phase.
  always_comb begin
    flags.first    = (phase_q == '0);
    flags.last     = (phase_q == PH_LAST);
    phase_nx       = flags.last ? '0 : phase_q + PH_W'(1);
    flags.start_nx = (phase_nx == '0);
    flags.mid_nx   = (phase_nx == PH_MID);
    phase_d        = phase_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/pwm_ramp_cmp.sv
module pwm_ramp_cmp #(
  parameter  int CMD_W      = 10,
  parameter  int PERIOD_CYC = 278,
  parameter  int RAMP_OFS   = 278,
  localparam int PH_W       = $clog2(PERIOD_CYC),
  localparam int RW         = CMD_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMD_W-1:0] duty_cmd,
  input  logic [PH_W-1:0]  phase_nx,
  input  logic             start_nx,
  output logic             ramp_trip
);

  logic [CMD_W-1:0] duty_q;
  logic [CMD_W-1:0] duty_d;
  logic             load_en;
  logic [RW-1:0]    ramp_nx;

  // The command is captured at the edge that enters phase 0. In that
  // same decision the fresh command is used directly.
  always_comb begin
    load_en   = start_nx;
    duty_d    = load_en ? duty_cmd : duty_q;
    ramp_nx   = RW'(RAMP_OFS) + RW'(phase_nx);
    ramp_trip = (ramp_nx >= {1'b0, duty_d});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
    end else if (load_en) begin
      duty_q <= duty_d;
    end
  end

endmodule

// File: rtl/pwm_run_guard.sv
module pwm_run_guard #(
  parameter  int MAX_RUNS = 20,
  localparam int RUN_W    = $clog2(MAX_RUNS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_q,
  input  logic             fault,
  input  logic             first,
  input  logic             last,
  input  logic             mid_nx,
  output logic             force_off,
  output logic [RUN_W-1:0] runs_q
);

  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(MAX_RUNS);

  logic             hi_all_q;
  logic             hi_all_d;
  logic             full_period;
  logic             runs_en;
  logic [RUN_W-1:0] runs_d;

  always_comb begin
    // Tracks whether the request has been high in every cycle so far.
    if (fault) begin
      hi_all_d = 1'b0;
    end else if (first) begin
      hi_all_d = pwm_q;
    end else begin
      hi_all_d = hi_all_q & pwm_q;
    end

    full_period = hi_all_q & pwm_q;
    runs_en     = fault | last;

    if (fault || !full_period) begin
      runs_d = '0;
    end else if (runs_q == RUN_MAX) begin
      runs_d = runs_q;
    end else begin
      runs_d = runs_q + RUN_W'(1);
    end

    force_off = (runs_q == RUN_MAX) && mid_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_all_q <= 1'b0;
    end else begin
      hi_all_q <= hi_all_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runs_q <= '0;
    end else if (runs_en) begin
      runs_q <= runs_d;
    end
  end

endmodule

// File: rtl/pwm_latch.sv
module pwm_latch
  import pwm_mod_pkg::*;
#(
  parameter  int MIN_ON = 23,
  localparam int ON_W   = $clog2(MIN_ON + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic ramp_trip,
  input  logic force_off,
  input  logic fault,
  output logic pwm_q
);

  localparam logic [ON_W-1:0] ON_MIN = ON_W'(MIN_ON);

  clr_cause_e      cause;
  logic            pwm_d;
  logic            min_done;
  logic [ON_W-1:0] on_cnt_q;
  logic [ON_W-1:0] on_cnt_d;

  always_comb begin
    // The ramp may end a running pulse only after the minimum on-time.
    // It always blocks a set while the request is low.
    min_done = !pwm_q || (on_cnt_q >= ON_MIN);

    if (fault) begin
      cause = CLR_FAULT;
    end else if (force_off) begin
      cause = CLR_TIMEOUT;
    end else if (ramp_trip && min_done) begin
      cause = CLR_RAMP;
    end else begin
      cause = CLR_NONE;
    end

    // Clear dominates set.
    case (cause)
      CLR_NONE: pwm_d = set_req | pwm_q;
      default:  pwm_d = 1'b0;
    endcase

    if (!pwm_d) begin
      on_cnt_d = '0;
    end else if (on_cnt_q == ON_MIN) begin
      on_cnt_d = on_cnt_q;
    end else begin
      on_cnt_d = on_cnt_q + ON_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q    <= 1'b0;
      on_cnt_q <= '0;
    end else begin
      pwm_q    <= pwm_d;
      on_cnt_q <= on_cnt_d;
    end
  end

endmodule

// File: rtl/pwm_maxduty_mod.sv
module pwm_maxduty_mod
  import pwm_mod_pkg::*;
#(
  parameter int CMD_W      = 10,
  parameter int PERIOD_CYC = 278,
  parameter int RAMP_OFS   = 278,
  parameter int MIN_ON     = 23,
  parameter int MAX_RUNS   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMD_W-1:0] duty_cmd,
  input  logic             fault,
  output logic             pwm_req
);

  localparam int PH_W  = $clog2(PERIOD_CYC);
  localparam int RUN_W = $clog2(MAX_RUNS + 1);

  logic             rst_sync_n;
  logic [PH_W-1:0]  phase_q;
  logic [PH_W-1:0]  phase_nx;
  phase_flags_t     flags;
  logic             ramp_trip;
  logic             force_off;
  logic [RUN_W-1:0] runs_q;
  logic             pwm_q;

  pwm_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  pwm_phase_gen #(.PERIOD_CYC(PERIOD_CYC)) u_phase (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .phase_q  (phase_q),
    .phase_nx (phase_nx),
    .flags    (flags)
  );

  pwm_ramp_cmp #(
    .CMD_W      (CMD_W),
    .PERIOD_CYC (PERIOD_CYC),
    .RAMP_OFS   (RAMP_OFS)
  ) u_ramp (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .duty_cmd  (duty_cmd),
    .phase_nx  (phase_nx),
    .start_nx  (flags.start_nx),
    .ramp_trip (ramp_trip)
  );

  pwm_run_guard #(.MAX_RUNS(MAX_RUNS)) u_guard (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .pwm_q     (pwm_q),
    .fault     (fault),
    .first     (flags.first),
    .last      (flags.last),
    .mid_nx    (flags.mid_nx),
    .force_off (force_off),
    .runs_q    (runs_q)
  );

  pwm_latch #(.MIN_ON(MIN_ON)) u_latch (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .set_req   (flags.start_nx),
    .ramp_trip (ramp_trip),
    .force_off (force_off),
    .fault     (fault),
    .pwm_q     (pwm_q)
  );

  assign pwm_req = pwm_q;

endmodule

// File: rtl/pwm_maxduty_chk.sv
module pwm_maxduty_chk #(
  parameter int PERIOD_CYC = 278,
  parameter int MIN_ON     = 23,
  parameter int MAX_RUNS   = 20,
  parameter int PH_W       = 9,
  parameter int RUN_W      = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwm_req,
  input logic             fault,
  input logic [PH_W-1:0]  phase,
  input logic [RUN_W-1:0] runs
);

  localparam int HL_W = $clog2(MIN_ON + 1);

  logic            was_hi;
  logic            was_fault;
  logic [HL_W-1:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      was_hi    <= 1'b0;
      was_fault <= 1'b0;
      hi_len    <= '0;
    end else begin
      was_hi    <= pwm_req;
      was_fault <= fault;
      if (!pwm_req) begin
        hi_len <= '0;
      end else if (hi_len != HL_W'(MIN_ON)) begin
        hi_len <= hi_len + HL_W'(1);
      end
    end
  end

  a_r1_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase < PH_W'(PERIOD_CYC));

  a_r1_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_req) |-> (phase == '0));

  a_r8_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !pwm_req);

  a_r5_half_off: assert property (@(posedge clk) disable iff (!rst_n)
    (runs == RUN_W'(MAX_RUNS) && phase >= PH_W'(PERIOD_CYC / 2)) |-> !pwm_req);

  a_r6_runs_bound: assert property (@(posedge clk) disable iff (!rst_n)
    runs <= RUN_W'(MAX_RUNS));

  a_r7_min_on: assert property (@(posedge clk) disable iff (!rst_n)
    (was_hi && !pwm_req && !was_fault) |-> (hi_len >= HL_W'(MIN_ON)));

endmodule

bind pwm_maxduty_mod pwm_maxduty_chk #(
  .PERIOD_CYC (PERIOD_CYC),
  .MIN_ON     (MIN_ON),
  .MAX_RUNS   (MAX_RUNS),
  .PH_W       (PH_W),
  .RUN_W      (RUN_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .pwm_req (pwm_req),
  .fault   (fault),
  .phase   (phase_q),
  .runs    (runs_q)
);

// File: tb/pwm_maxduty_mod_test.sv
module pwm_maxduty_mod_test;

  localparam int P        = 278;
  localparam int OFS      = 278;
  localparam int CW       = 10;
  localparam int MIN_ON   = 23;
  localparam int MAX_RUNS = 20;
  localparam int HALF     = P / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] duty_cmd = CW'(OFS + HALF);
  logic          fault = 1'b0;
  logic          pwm_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit prev_full = 1'b0;
  int brun = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_maxduty_mod #(
    .CMD_W(CW), .PERIOD_CYC(P), .RAMP_OFS(OFS), .MIN_ON(MIN_ON), .MAX_RUNS(MAX_RUNS)
  ) uut (
    .clk(clk), .rst_n(rst_n), .duty_cmd(duty_cmd), .fault(fault), .pwm_req(pwm_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected high cycles in one period.
  function automatic int exp_high(input int d, input bit pf, input int br);
    int n;
    int e;
    n = d - OFS;
    if (n < 0) n = 0;
    if (n > P) n = P;
    if (n == 0) return 0;
    e = (pf || n >= MIN_ON) ? n : MIN_ON;
    if (br == MAX_RUNS && e > HALF) e = HALF;
    return e;
  endfunction

  // Entered just after the last-phase sample of the previous period.
  task automatic run_period(input int d, input int mid_d, input bit mid_chg, input string req);
    int h = 0;
    bit shape_ok = 1'b1;
    bit seen_low = 1'b0;
    int e;
    e = exp_high(d, prev_full, brun);
    duty_cmd = CW'(d);
    for (int k = 0; k < P; k++) begin
      @(negedge clk);
      if (pwm_req) begin
        h++;
        if (seen_low) shape_ok = 1'b0;
      end else begin
        seen_low = 1'b1;
      end
      if (mid_chg && k == P / 4) duty_cmd = CW'(mid_d);
    end
    chk(h == e, req, h, e);
    chk(shape_ok, "R1 single run from phase 0", int'(shape_ok), 1);
    prev_full = (e == P);
    brun = (e == P) ? brun + 1 : 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int wait_cnt;
    int h;
    void'($urandom(32'd4471));

    // R10: reset state
    repeat (4) @(negedge clk);
    chk(pwm_req == 1'b0, "R10 low in reset", int'(pwm_req), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(pwm_req == 1'b0, "R10 low before first period", int'(pwm_req), 0);

    // Lock onto the first period start.
    wait_cnt = 0;
    while (!pwm_req && wait_cnt < 2 * P) begin
      @(negedge clk);
      wait_cnt++;
    end
    chk(pwm_req == 1'b1, "R1 first pulse seen", int'(pwm_req), 1);
    h = 1;
    for (int k = 1; k < P; k++) begin
      @(negedge clk);
      if (pwm_req) h++;
    end
    chk(h == HALF, "R2 first period width", h, HALF);
    prev_full = 1'b0;
    brun = 0;

    // R3: clear dominates set
    run_period(OFS, 0, 0, "R3 duty at offset");
    run_period(OFS - 50, 0, 0, "R3 duty below offset");
    run_period(0, 0, 0, "R3 duty zero");

    // R2: trailing edge
    run_period(OFS + 100, 0, 0, "R2 width 100");
    run_period(OFS + P - 1, 0, 0, "R2 width P-1");

    // R7: minimum on-time from low
    run_period(OFS + 1, 0, 0, "R7 stretch 1");
    run_period(OFS + MIN_ON - 1, 0, 0, "R7 stretch MIN_ON-1");
    run_period(OFS + MIN_ON, 0, 0, "R7 exact MIN_ON");

    // R9: late command change ignored
    run_period(OFS + 200, OFS + 100, 1, "R9 mid-period change");

    // R4: full duty, then a short pulse continuing from a full period
    run_period(OFS + P, 0, 0, "R4 full duty");
    run_period(OFS + P + 30, 0, 0, "R4 above full duty");
    run_period(OFS + 2, 0, 0, "R7 continuation not stretched");

    // R5: timeout after MAX_RUNS full periods
    for (int i = 0; i < MAX_RUNS + 2; i++) run_period(OFS + P, 0, 0, "R5 run and timeout");

    // R6: a partial period restarts the count
    for (int i = 0; i < MAX_RUNS - 1; i++) run_period(OFS + P, 0, 0, "R6 run");
    run_period(OFS + P - 1, 0, 0, "R6 break");
    for (int i = 0; i < MAX_RUNS + 1; i++) run_period(OFS + P, 0, 0, "R6 fresh run");

    // R8: fault during a full run
    for (int i = 0; i < 5; i++) run_period(OFS + P, 0, 0, "R8 pre-fault run");
    duty_cmd = CW'(OFS + P);
    h = 0;
    for (int k = 0; k < P; k++) begin
      @(negedge clk);
      if (pwm_req) h++;
      if (k == P / 4 + 1) chk(pwm_req == 1'b0, "R8 low after fault", int'(pwm_req), 0);
      if (k == P / 4) fault = 1'b1;
    end
    chk(h == P / 4 + 1, "R8 highs before fault", h, P / 4 + 1);
    h = 0;
    for (int k = 0; k < P; k++) begin
      @(negedge clk);
      if (pwm_req) h++;
    end
    chk(h == 0, "R8 low while fault held", h, 0);
    fault = 1'b0;
    prev_full = 1'b0;
    brun = 0;
    for (int i = 0; i < MAX_RUNS + 1; i++) run_period(OFS + P, 0, 0, "R8 count cleared by fault");

    // Random mix
    for (int i = 0; i < 60; i++) begin
      int d;
      int md;
      bit mc;
      d  = int'($urandom_range(0, OFS + P + 20));
      md = int'($urandom_range(0, OFS + P + 20));
      mc = 1'($urandom_range(0, 1));
      run_period(d, md, mc, "R2 random duty");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule